// File: doc/BRIEF.md
# Serial Command Word Readout Port

This block holds one command word in a shift register and lets a processor drain it one bit per port read. The word enters in parallel from an external source. A processor then issues reads of a decoded input port. Each read that passes the gating moves the register by one place, and the outgoing bit is always present on bit 0 of the processor data bus. Once a full word has gone out, the block refuses further reads. It stays in that state until the processor writes a separate arm port, which readies it for the next word.

Shifting is gated three ways. A reset inhibit latch is set by the synchronous reset and is cleared only by the arm write. An active external clock condition holds the register, and so does a pulse on the external load input. A bit counter tracks how many places have been shifted. Parameters set the word width and the bit order, with MSB first as the default.

Top module: `serial_word_port`

## Requirements
- R1: While `rst` is high at a clock edge, the register, the bit counter, `word_done` and `armed` are all cleared, and the inhibit latch is set. After reset, `ser_bit`, `word_done` and `armed` read 0.
- R2: A write strobe (`wr_sel` and `wr_stb` both high) clears the inhibit latch, sets `armed`, clears the bit counter and clears `word_done`, effective from the next cycle.
- R3: An `ext_load` pulse while `armed` is 1 copies `ext_word` into the register, clears the counter and `word_done`, and drops `armed`. An `ext_load` pulse while `armed` is 0 leaves the register unchanged.
- R4: A shift happens only in a cycle where `rd_sel` and `rd_stb` are both high. Either one alone has no effect on the register.
- R5: A cycle with `ext_clk_act` high performs no shift, even when a qualified read is present.
- R6: A cycle with `ext_load` high performs no shift, whether or not the load is accepted.
- R7: With MSB_FIRST=1, `ser_bit` equals register bit WORD_W-1 before each read. A shift moves the register one place toward the MSB and fills bit 0 with 0, so the next read presents the next lower bit of the loaded word.
- R8: `word_done` rises in the cycle after the WORD_W-th shift since the last load or arm. While `word_done` is 1, reads leave the register and `ser_bit` unchanged.
- R9: While the inhibit latch is set, reads cause no shift and no count, so WORD_W reads after reset leave `word_done` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_sel | input | 1 | Decoded select of the readout input port |
| rd_stb | input | 1 | Processor input (read) strobe |
| wr_sel | input | 1 | Decoded select of the arm output port |
| wr_stb | input | 1 | Processor output (write) strobe |
| ext_clk_act | input | 1 | External clock condition active; holds shifting |
| ext_load | input | 1 | External parallel load pulse |
| ext_word | input | WORD_W | Parallel word from the external source |
| ser_bit | output | 1 | Outgoing register bit, driven onto data bus bit 0 |
| word_done | output | 1 | Full word has been shifted out |
| armed | output | 1 | Ready to accept a parallel load |

## Verification
The bench walks a table of read, external-clock and load combinations across a loaded word. A design that decoded only one of the two read signals would let the bit stream slip ahead, and so would one that ignored a blocking condition. The reads that finish the word are checked at the exact boundary: a counter off by one raises `word_done` a read early or late. After `word_done`, further reads must leave the output alone. A load attempted while disarmed must not overwrite the drained register. A run of WORD_W reads straight after reset must not complete a word, which would happen if the inhibit latch were missing.

// File: rtl/swp_pkg.sv
package swp_pkg;
   function automatic int count_bits(input int width);
      return $clog2(width + 1);
   endfunction
endpackage

// File: rtl/swp_strobe_gate.sv
module swp_strobe_gate (
   input  logic rd_sel,
   input  logic rd_stb,
   input  logic inhibit,
   input  logic xclk_act,
   input  logic xload,
   input  logic full,
   output logic shift_en
);
   logic rd_hit;
   logic pass_ok;

   always_comb begin
      rd_hit   = rd_sel & rd_stb;
      pass_ok  = ~inhibit & ~xclk_act & ~xload & ~full;
      shift_en = rd_hit & pass_ok;
   end
endmodule

// File: rtl/swp_arm_ctrl.sv
module swp_arm_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic wr_sel,
   input  logic wr_stb,
   input  logic xload,
   output logic arm_hit,
   output logic take_load,
   output logic inhibit,
   output logic armed
);
   always_comb begin
      arm_hit   = wr_sel & wr_stb;
      take_load = xload & armed & ~arm_hit;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         inhibit <= 1'b1;
         armed   <= 1'b0;
      end else if (arm_hit) begin
         inhibit <= 1'b0;
         armed   <= 1'b1;
      end else if (take_load) begin
         armed   <= 1'b0;
      end
   end

   // R2
   a_r2_arm_releases: assert property (@(posedge clk) disable iff (rst)
      arm_hit |=> (armed && !inhibit));
   // R3
   a_r3_load_disarms: assert property (@(posedge clk) disable iff (rst)
      take_load |=> !armed);
endmodule

// File: rtl/swp_bit_counter.sv
module swp_bit_counter #(
   parameter int WORD_W = 64,
   localparam int CNT_W = swp_pkg::count_bits(WORD_W)
) (
   input  logic clk,
   input  logic rst,
   input  logic clear,
   input  logic step,
   output logic full
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WORD_W);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clear)
         cnt_q <= '0;
      else if (step && (cnt_q != LIMIT))
         cnt_q <= cnt_q + 1'b1;
   end

   assign full = (cnt_q == LIMIT);

   // R8
   a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LIMIT);
   // R8
   a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
      (full && !clear) |=> full);
endmodule

// File: rtl/swp_shift_reg.sv
module swp_shift_reg #(
   parameter int WORD_W    = 64,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              shift,
   output logic              ser_bit
);
   logic [WORD_W-1:0] q;
   logic [WORD_W-1:0] q_shifted;

   generate
      if (MSB_FIRST) begin : g_msb
         assign q_shifted = {q[WORD_W-2:0], 1'b0};
         assign ser_bit   = q[WORD_W-1];
      end else begin : g_lsb
         assign q_shifted = {1'b0, q[WORD_W-1:1]};
         assign ser_bit   = q[0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (load)
         q <= load_word;
      else if (shift)
         q <= q_shifted;
   end
endmodule

// File: rtl/serial_word_port.sv
module serial_word_port #(
   parameter int WORD_W    = 64,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_sel,
   input  logic              rd_stb,
   input  logic              wr_sel,
   input  logic              wr_stb,
   input  logic              ext_clk_act,
   input  logic              ext_load,
   input  logic [WORD_W-1:0] ext_word,
   output logic              ser_bit,
   output logic              word_done,
   output logic              armed
);
   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("serial_word_port: WORD_W must be at least 2");
      end
   endgenerate

   logic arm_hit;
   logic take_load;
   logic inhibit;
   logic shift_en;

   swp_arm_ctrl u_arm (
      .clk       (clk),
      .rst       (rst),
      .wr_sel    (wr_sel),
      .wr_stb    (wr_stb),
      .xload     (ext_load),
      .arm_hit   (arm_hit),
      .take_load (take_load),
      .inhibit   (inhibit),
      .armed     (armed)
   );

   swp_strobe_gate u_gate (
      .rd_sel   (rd_sel),
      .rd_stb   (rd_stb),
      .inhibit  (inhibit),
      .xclk_act (ext_clk_act),
      .xload    (ext_load),
      .full     (word_done),
      .shift_en (shift_en)
   );

   swp_bit_counter #(.WORD_W(WORD_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clear (arm_hit | take_load),
      .step  (shift_en),
      .full  (word_done)
   );

   swp_shift_reg #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_sreg (
      .clk       (clk),
      .rst       (rst),
      .load      (take_load),
      .load_word (ext_word),
      .shift     (shift_en),
      .ser_bit   (ser_bit)
   );

   // R5: an external clock condition freezes the output bit
   a_r5_xclk_freezes: assert property (@(posedge clk) disable iff (rst)
      (ext_clk_act && !arm_hit && !ext_load) |=> $stable(ser_bit));
   // R4: no qualified read, no movement
   a_r4_needs_both: assert property (@(posedge clk) disable iff (rst)
      (!(rd_sel && rd_stb) && !arm_hit && !ext_load) |=> $stable(ser_bit));
   // R9: inhibit latch holds the register
   a_r9_inhibit_freezes: assert property (@(posedge clk) disable iff (rst)
      (inhibit && !arm_hit) |=> $stable(ser_bit));
   // R8: a finished word is not disturbed by reads
   a_r8_done_freezes: assert property (@(posedge clk) disable iff (rst)
      (word_done && !arm_hit && !ext_load) |=> $stable(ser_bit));
endmodule

// File: tb/serial_word_port_tb_top.sv
module serial_word_port_tb_top;
   localparam int W = 64;
   localparam int NV = 12;
   // each entry: {rd_sel, rd_stb, ext_clk_act, ext_load, shift_expected}
   localparam logic [4:0] VEC [NV] = '{
      5'b11001, 5'b10000, 5'b01000, 5'b11100, 5'b11010, 5'b11001,
      5'b00100, 5'b11110, 5'b00010, 5'b11001, 5'b01010, 5'b11001
   };
   localparam logic [W-1:0] WORD_A = 64'hA5C3_0F96_1E2D_7B48;
   localparam logic [W-1:0] WORD_B = 64'h8000_0000_0000_0001;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic rd_sel = 1'b0, rd_stb = 1'b0, wr_sel = 1'b0, wr_stb = 1'b0;
   logic ext_clk_act = 1'b0, ext_load = 1'b0;
   logic [W-1:0] ext_word = '0;
   logic ser_bit, word_done, armed;

   int checks = 0;
   int failures = 0;

   logic [W-1:0] m_word;
   int m_cnt;
   logic m_done, m_armed, m_latch;

   always #2 clk = ~clk;

   serial_word_port #(.WORD_W(W)) dut_i (
      .clk(clk), .rst(rst), .rd_sel(rd_sel), .rd_stb(rd_stb),
      .wr_sel(wr_sel), .wr_stb(wr_stb), .ext_clk_act(ext_clk_act),
      .ext_load(ext_load), .ext_word(ext_word),
      .ser_bit(ser_bit), .word_done(word_done), .armed(armed)
   );

   task automatic check_all(input string req);
      checks++;
      if (ser_bit !== m_word[W-1] || word_done !== m_done || armed !== m_armed) begin
         failures++;
         $display("FAIL %s: bit/done/armed actual=%b%b%b expected=%b%b%b", req,
                  ser_bit, word_done, armed, m_word[W-1], m_done, m_armed);
      end
   endtask

   task automatic step(input logic s, input logic r, input logic xc, input logic xl,
                       input logic aw, input logic [W-1:0] lw, input logic sh,
                       input string req);
      rd_sel = s; rd_stb = r; ext_clk_act = xc; ext_load = xl;
      wr_sel = aw; wr_stb = aw; ext_word = lw;
      @(negedge clk);
      if (aw) begin
         m_latch = 1'b0; m_armed = 1'b1; m_cnt = 0; m_done = 1'b0;
      end else if (xl && m_armed) begin
         m_word = lw; m_armed = 1'b0; m_cnt = 0; m_done = 1'b0;
      end else if (sh && !m_latch && !m_done) begin
         m_word = {m_word[W-2:0], 1'b0};
         m_cnt++;
         m_done = (m_cnt == W);
      end
      rd_sel = 0; rd_stb = 0; ext_clk_act = 0; ext_load = 0; wr_sel = 0; wr_stb = 0;
      check_all(req);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_word = '0; m_cnt = 0; m_done = 0; m_armed = 0; m_latch = 1;
   endtask

   initial begin
      #(4 * 200000);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      check_all("R1 reset state");

      // R9: reads while inhibited never complete a word
      for (int i = 0; i < W; i++) step(1, 1, 0, 0, 0, '0, 0, "R9 inhibit");
      checks++;
      if (word_done !== 1'b0) begin
         failures++;
         $display("FAIL R9: word_done actual=%b expected=0", word_done);
      end

      step(0, 0, 0, 0, 1, '0, 0, "R2 arm");
      step(0, 0, 0, 1, 0, WORD_A, 0, "R3 load accepted");

      // R4 R5 R6 gating table
      for (int v = 0; v < NV; v++)
         step(VEC[v][4], VEC[v][3], VEC[v][2], VEC[v][1], 0, '1, VEC[v][0],
              "R4/R5/R6 gating vector");

      // R7 R8: drain the rest, MSB first, done exactly at the end
      while (m_cnt < W) step(1, 1, 0, 0, 0, '0, 1, "R7 bit order R8 done");
      for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, '0, 1, "R8 reads ignored when done");

      // R3: load while disarmed is ignored
      step(0, 0, 0, 1, 0, '1, 0, "R3 load ignored when disarmed");
      checks++;
      if (ser_bit !== 1'b0) begin
         failures++;
         $display("FAIL R3: ser_bit actual=%b expected=0", ser_bit);
      end

      // second word: re-arm clears done
      step(0, 0, 0, 0, 1, '0, 0, "R2 re-arm clears done");
      step(0, 0, 0, 1, 0, WORD_B, 0, "R3 second load");
      while (m_cnt < W) step(1, 1, 0, 0, 0, '0, 1, "R7 R8 second word");

      // R1: reset mid-word
      step(0, 0, 0, 0, 1, '0, 0, "R2 arm before reset");
      step(0, 0, 0, 1, 0, WORD_A, 0, "R3 load before reset");
      do_reset();
      check_all("R1 reset clears mid-word");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule